// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits beside a PCIe root port and watches the inbound write traffic coming up from downstream devices. Software programs a 64-bit doorbell address, a word of per-vector enables and a word of per-vector masks through a 32-bit register port. When a device writes a full 4-byte word to exactly that doorbell address, the block takes the written value as a vector number. If the enable bit for that vector is set, it latches the matching bit in a status word. The block does not signal once per message. It drives one level interrupt toward the CPU that reflects pending, unmasked vectors.

The snoop port sees every inbound request together with its direction, byte count, address and data. The block claims only the writes it absorbs. Reads aimed at the doorbell address are never claimed and continue on the normal device-read path. Software services the interrupt by reading the status word and writing ones back to the bits it has handled. The interrupt drops once no status bit remains set.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset the doorbell address, enable, mask and status words all read zero, and `msi_irq` and `snp_claim` are low.
- R2: Register offset 0x820 holds bits 31:0 of the doorbell address and 0x824 holds bits 63:32. A write to either offset changes only its own half, and both halves read back what was written.
- R3: The enable word at 0x828 and the mask word at 0x82C are read/write. Offsets that no register decodes read as zero.
- R4: A write request (snp_write=1) with snp_nbytes=4, an address equal to the doorbell address, a nonzero enable word and data v, where v is below 32 and enable bit v is set, sets status bit v (readable at 0x830) at the next clock edge. Status bits that are already set stay set.
- R5: A captured write whose vector has its enable bit clear leaves the status word unchanged.
- R6: Write data of 32 or more selects no vector and leaves the status word unchanged.
- R7: A write is not captured, and `snp_claim` stays low, when snp_nbytes is not 4, when any of the 64 address bits differs from the doorbell address, or while the enable word is all zero.
- R8: A read request (snp_write=0) to the doorbell address is not captured. It leaves `snp_claim` low and the status word unchanged.
- R9: `snp_claim` is high, in the same cycle as the request, for a 4-byte write that hits the live doorbell address, whether or not a vector is latched.
- R10: In the cycle after a capture, `msi_irq` is high if status AND NOT mask is nonzero. A capture that leaves only masked status bits set does not raise `msi_irq`.
- R11: Writing to the status word at 0x830 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R12: `msi_irq` stays high while any status bit remains set, and goes low at the same edge at which the status word becomes all zero.
- R13: When a capture and a status clear hit the same bit in the same cycle, the capture wins and the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| snp_valid | input | 1 | Inbound request present this cycle |
| snp_write | input | 1 | 1 for a write request, 0 for a read request |
| snp_addr | input | 64 | Inbound request address |
| snp_nbytes | input | 3 | Request size in bytes |
| snp_data | input | 32 | Inbound write data |
| snp_claim | output | 1 | Request is absorbed as a doorbell write |
| msi_irq | output | 1 | Level interrupt toward the CPU |

## Verification
Capture is driven with write requests that each differ from a hit in exactly one respect: the vector's enable bit, a data value beyond the vector range, the byte count, the low address word, the high address word, the request direction, and an all-zero enable word. Each of these is checked to leave the status word and the claim line untouched. Captures are tried on unmasked and on masked vectors, so a wrong mask polarity and an interrupt that fires for every message can be told apart. Partial and zero-valued status writes show whether clearing acts per bit and whether the interrupt waits for the whole word to empty. A capture that lands in the same cycle as a clear of the same bit shows which of the two takes priority.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int unsigned REG_AW  = 12;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BUS_AW  = 64;
    localparam int unsigned SIZE_W  = 3;

    // Register offsets decoded by software drivers
    localparam logic [REG_AW-1:0] OFF_DOORBELL_LO = 12'h820;
    localparam logic [REG_AW-1:0] OFF_DOORBELL_HI = 12'h824;
    localparam logic [REG_AW-1:0] OFF_VEC_ENABLE  = 12'h828;
    localparam logic [REG_AW-1:0] OFF_VEC_MASK    = 12'h82C;
    localparam logic [REG_AW-1:0] OFF_VEC_PENDING = 12'h830;

    localparam logic [SIZE_W-1:0] FULL_WORD_BYTES = 3'd4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DB_LO,
        SEL_DB_HI,
        SEL_ENABLE,
        SEL_MASK,
        SEL_PENDING
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [BUS_AW-1:0] addr;
        logic [SIZE_W-1:0] nbytes;
        logic [WORD_W-1:0] data;
    } snoop_req_t;

    function automatic reg_sel_e decode_offset(input logic [REG_AW-1:0] off);
        reg_sel_e sel;
        case (off)
            OFF_DOORBELL_LO: sel = SEL_DB_LO;
            OFF_DOORBELL_HI: sel = SEL_DB_HI;
            OFF_VEC_ENABLE:  sel = SEL_ENABLE;
            OFF_VEC_MASK:    sel = SEL_MASK;
            OFF_VEC_PENDING: sel = SEL_PENDING;
            default:         sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int unsigned NUM_VEC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [NUM_VEC-1:0]   pending,
    output logic [WORD_W-1:0]    rdata,
    output logic [BUS_AW-1:0]    doorbell,
    output logic [NUM_VEC-1:0]   vec_enable,
    output logic [NUM_VEC-1:0]   vec_mask,
    output logic [NUM_VEC-1:0]   pending_clr
);

    localparam int unsigned HALF = BUS_AW / 2;

    reg_sel_e           sel;
    logic [HALF-1:0]    db_lo_q, db_hi_q;
    logic [NUM_VEC-1:0] en_q, mask_q;

    assign sel = decode_offset(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            db_lo_q <= '0;
            db_hi_q <= '0;
            en_q    <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DB_LO:  db_lo_q <= wdata[HALF-1:0];
                SEL_DB_HI:  db_hi_q <= wdata[HALF-1:0];
                SEL_ENABLE: en_q    <= wdata[NUM_VEC-1:0];
                SEL_MASK:   mask_q  <= wdata[NUM_VEC-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        pending_clr = '0;
        if (wr_en && sel == SEL_PENDING)
            pending_clr = wdata[NUM_VEC-1:0];
    end

    always_comb begin
        case (sel)
            SEL_DB_LO:   rdata = WORD_W'(db_lo_q);
            SEL_DB_HI:   rdata = WORD_W'(db_hi_q);
            SEL_ENABLE:  rdata = WORD_W'(en_q);
            SEL_MASK:    rdata = WORD_W'(mask_q);
            SEL_PENDING: rdata = WORD_W'(pending);
            default:     rdata = '0;
        endcase
    end

    assign doorbell   = {db_hi_q, db_lo_q};
    assign vec_enable = en_q;
    assign vec_mask   = mask_q;

    // R2: writing the low word never disturbs the high word
    assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_DOORBELL_LO) |=> (doorbell[BUS_AW-1:HALF] == $past(doorbell[BUS_AW-1:HALF])));

    // R2: writing the high word never disturbs the low word
    assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_DOORBELL_HI) |=> (doorbell[HALF-1:0] == $past(doorbell[HALF-1:0])));

endmodule

// File: rtl/msi_cap_snoop.sv
module msi_cap_snoop
    import msi_cap_pkg::*;
#(
    parameter int unsigned NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  snoop_req_t         req,
    input  logic [BUS_AW-1:0]  doorbell,
    input  logic [NUM_VEC-1:0] vec_enable,
    output logic               claim,
    output logic [NUM_VEC-1:0] set_vec
);

    localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic               window_live;
    logic               addr_hit;
    logic               vec_in_range;
    logic [IDX_W-1:0]   vec_idx;
    logic [NUM_VEC-1:0] vec_onehot;

    assign window_live  = |vec_enable;
    assign addr_hit     = (req.addr == doorbell);
    assign claim        = req.valid && req.write && (req.nbytes == FULL_WORD_BYTES)
                          && addr_hit && window_live;
    assign vec_in_range = (req.data < WORD_W'(NUM_VEC));
    assign vec_idx      = req.data[IDX_W-1:0];
    assign vec_onehot   = NUM_VEC'(1) << vec_idx;

    always_comb begin
        set_vec = '0;
        if (claim && vec_in_range)
            set_vec = vec_onehot & vec_enable;
    end

    // R5: a latched vector always has its enable bit set
    assert_set_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        (set_vec & ~vec_enable) == '0);

    // R6: at most one vector per message
    assert_one_vector_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_vec));

    // R8: a read request is never claimed
    assert_read_unclaimed_R8: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.write) |-> !claim);

    // R7: claims only for full-word requests
    assert_full_word_R7: assert property (@(posedge clk) disable iff (rst)
        claim |-> (req.nbytes == FULL_WORD_BYTES));

endmodule

// File: rtl/msi_cap_pending.sv
module msi_cap_pending #(
    parameter int unsigned NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] set_vec,
    input  logic [NUM_VEC-1:0] clr_vec,
    input  logic [NUM_VEC-1:0] vec_mask,
    output logic [NUM_VEC-1:0] pending,
    output logic               irq
);

    logic [NUM_VEC-1:0] pend_q, pend_d;
    logic               irq_q, irq_d;
    logic               captured;

    assign captured = |set_vec;

    always_comb begin
        // set is applied after clear, so a capture wins over a clear
        pend_d = (pend_q & ~clr_vec) | set_vec;
        if (pend_d == '0)
            irq_d = 1'b0;
        else if (captured && ((pend_d & ~vec_mask) != '0))
            irq_d = 1'b1;
        else
            irq_d = irq_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= irq_d;
        end
    end

    assign pending = pend_q;
    assign irq     = irq_q;

    // R4: pending bits are sticky unless explicitly cleared
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0));

    // R12: the interrupt is never high with nothing pending
    assert_irq_needs_pending_R12: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |-> !irq_q);

    // R10: the interrupt only rises after a capture
    assert_rise_after_capture_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(captured));

    // R13: a captured bit is set afterwards even if cleared in the same cycle
    assert_capture_wins_R13: assert property (@(posedge clk) disable iff (rst)
        captured |=> (($past(set_vec) & ~pend_q) == '0));

endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int unsigned NUM_VEC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [63:0]       snp_addr,
    input  logic [2:0]        snp_nbytes,
    input  logic [31:0]       snp_data,
    output logic              snp_claim,
    output logic              msi_irq
);

    snoop_req_t         req;
    logic [BUS_AW-1:0]  doorbell;
    logic [NUM_VEC-1:0] vec_enable, vec_mask, pending, pending_clr, set_vec;

    assign req = '{valid: snp_valid, write: snp_write, addr: snp_addr,
                   nbytes: snp_nbytes, data: snp_data};

    msi_cap_regs #(.NUM_VEC(NUM_VEC)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .pending     (pending),
        .rdata       (reg_rdata),
        .doorbell    (doorbell),
        .vec_enable  (vec_enable),
        .vec_mask    (vec_mask),
        .pending_clr (pending_clr)
    );

    msi_cap_snoop #(.NUM_VEC(NUM_VEC)) u_snoop (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .doorbell   (doorbell),
        .vec_enable (vec_enable),
        .claim      (snp_claim),
        .set_vec    (set_vec)
    );

    msi_cap_pending #(.NUM_VEC(NUM_VEC)) u_pending (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_vec  (pending_clr),
        .vec_mask (vec_mask),
        .pending  (pending),
        .irq      (msi_irq)
    );

endmodule

// File: tb/tb_msi_capture_ctrl.sv
`timescale 1ns/1ps
module tb_msi_capture_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        snp_valid, snp_write;
    logic [63:0] snp_addr;
    logic [2:0]  snp_nbytes;
    logic [31:0] snp_data;
    logic        snp_claim, msi_irq;

    always #5 clk = ~clk;

    msi_capture_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_valid(snp_valid),
        .snp_write(snp_write), .snp_addr(snp_addr), .snp_nbytes(snp_nbytes),
        .snp_data(snp_data), .snp_claim(snp_claim), .msi_irq(msi_irq)
    );

    typedef enum int { K_RDATA, K_IRQ, K_CLAIM } kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     chk_ev;
    int       n_checks = 0;
    int       n_fails  = 0;
    bit       finished = 0;

    localparam logic [63:0] DB = 64'hABCD_0001_0000_1000;

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RDATA: act = reg_rdata;
                    K_IRQ:   act = {31'd0, msi_irq};
                    default: act = {31'd0, snp_claim};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_chk(kind_e k, logic [31:0] e, string tag);
        sb_item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic reg_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic check_reg(logic [11:0] a, logic [31:0] e, string tag);
        reg_addr = a;
        #1;
        push_chk(K_RDATA, e, tag);
    endtask

    task automatic snoop(logic w, logic [63:0] a, logic [2:0] nb, logic [31:0] d,
                         logic exp_claim, string tag);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = w; snp_addr = a; snp_nbytes = nb; snp_data = d;
        #1;
        push_chk(K_CLAIM, {31'd0, exp_claim}, tag);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // capture and status clear in the same cycle
    task automatic snoop_and_clear(logic [31:0] vec, logic [31:0] clr);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = 1'b1; snp_addr = DB; snp_nbytes = 3'd4; snp_data = vec;
        reg_wr_en = 1'b1; reg_addr = 12'h830; reg_wdata = clr;
        @(negedge clk);
        snp_valid = 1'b0; reg_wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        snp_valid = 1'b0; snp_write = 1'b0; snp_addr = '0; snp_nbytes = '0; snp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_reg(12'h820, 32'h0, "R1 doorbell lo");
        check_reg(12'h824, 32'h0, "R1 doorbell hi");
        check_reg(12'h828, 32'h0, "R1 enable");
        check_reg(12'h82C, 32'h0, "R1 mask");
        check_reg(12'h830, 32'h0, "R1 status");
        push_chk(K_IRQ, 32'h0, "R1 irq");
        push_chk(K_CLAIM, 32'h0, "R1 claim");

        // R2: address halves
        reg_write(12'h820, 32'h1234_5600);
        reg_write(12'h824, 32'hABCD_0001);
        check_reg(12'h820, 32'h1234_5600, "R2 lo readback");
        check_reg(12'h824, 32'hABCD_0001, "R2 hi readback");
        reg_write(12'h820, 32'h0000_1000);
        check_reg(12'h824, 32'hABCD_0001, "R2 hi kept after lo write");
        check_reg(12'h820, 32'h0000_1000, "R2 lo rewritten");

        // R3: enable and mask
        reg_write(12'h828, 32'h0000_00F5);
        reg_write(12'h82C, 32'h0000_0080);
        check_reg(12'h828, 32'h0000_00F5, "R3 enable");
        check_reg(12'h82C, 32'h0000_0080, "R3 mask");
        check_reg(12'h834, 32'h0, "R3 undecoded offset");

        // R4 R9 R10: first capture
        snoop(1'b1, DB, 3'd4, 32'd2, 1'b1, "R9 claim on hit");
        check_reg(12'h830, 32'h0000_0004, "R4 status bit 2");
        push_chk(K_IRQ, 32'h1, "R10 irq after capture");

        // R5: disabled vector
        snoop(1'b1, DB, 3'd4, 32'd1, 1'b1, "R9 claim disabled vector");
        check_reg(12'h830, 32'h0000_0004, "R5 disabled vector");

        // R6: out of range data
        snoop(1'b1, DB, 3'd4, 32'd40, 1'b1, "R9 claim out of range");
        check_reg(12'h830, 32'h0000_0004, "R6 data 40 ignored");
        snoop(1'b1, DB, 3'd4, 32'h0000_0100, 1'b1, "R9 claim data 256");
        check_reg(12'h830, 32'h0000_0004, "R6 data 256 ignored");

        // R7: size and address mismatches
        snoop(1'b1, DB, 3'd2, 32'd0, 1'b0, "R7 claim size 2");
        check_reg(12'h830, 32'h0000_0004, "R7 size 2 ignored");
        snoop(1'b1, DB + 64'd4, 3'd4, 32'd0, 1'b0, "R7 claim low mismatch");
        check_reg(12'h830, 32'h0000_0004, "R7 low mismatch ignored");
        snoop(1'b1, DB ^ 64'h8000_0000_0000_0000, 3'd4, 32'd0, 1'b0, "R7 claim high mismatch");
        check_reg(12'h830, 32'h0000_0004, "R7 high mismatch ignored");

        // R8: read to doorbell
        snoop(1'b0, DB, 3'd4, 32'd0, 1'b0, "R8 read not claimed");
        check_reg(12'h830, 32'h0000_0004, "R8 read no capture");

        // R4: sticky accumulate
        snoop(1'b1, DB, 3'd4, 32'd0, 1'b1, "R9 claim vector 0");
        check_reg(12'h830, 32'h0000_0005, "R4 status accumulates");

        // R11 R12: write-1-to-clear
        reg_write(12'h830, 32'h0000_0001);
        check_reg(12'h830, 32'h0000_0004, "R11 clear bit 0");
        push_chk(K_IRQ, 32'h1, "R12 irq held while pending");
        reg_write(12'h830, 32'h0000_0000);
        check_reg(12'h830, 32'h0000_0004, "R11 zero write no effect");
        reg_write(12'h830, 32'h0000_0004);
        check_reg(12'h830, 32'h0000_0000, "R11 clear bit 2");
        push_chk(K_IRQ, 32'h0, "R12 irq low when empty");

        // R10: masked capture
        snoop(1'b1, DB, 3'd4, 32'd7, 1'b1, "R9 claim vector 7");
        check_reg(12'h830, 32'h0000_0080, "R4 status bit 7");
        push_chk(K_IRQ, 32'h0, "R10 masked capture no irq");
        reg_write(12'h830, 32'h0000_0080);
        check_reg(12'h830, 32'h0, "R11 clear bit 7");

        // R13: capture beats clear
        snoop(1'b1, DB, 3'd4, 32'd4, 1'b1, "R9 claim vector 4");
        push_chk(K_IRQ, 32'h1, "R10 irq vector 4");
        snoop_and_clear(32'd4, 32'h0000_0010);
        check_reg(12'h830, 32'h0000_0010, "R13 capture wins");
        push_chk(K_IRQ, 32'h1, "R13 irq stays high");
        reg_write(12'h830, 32'h0000_0010);
        push_chk(K_IRQ, 32'h0, "R12 irq low after final clear");

        // R7: window dead while enable is zero
        reg_write(12'h828, 32'h0);
        snoop(1'b1, DB, 3'd4, 32'd0, 1'b0, "R7 claim with enable zero");
        check_reg(12'h830, 32'h0, "R7 enable zero no capture");
        push_chk(K_IRQ, 32'h0, "R7 irq stays low");

        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule